// File: doc/BRIEF.md
# Pickup and Dropout Delay Timer

This block qualifies one logic input before it is allowed to change a registered output. A rising input must persist for a programmable number of processing intervals before the output asserts. A falling input must persist for a second, independently programmed number of intervals before the output deasserts. A one-cycle tick enable marks the processing intervals. The block evaluates the input, and advances its timing, only on cycles where that tick is high.

A setting of zero on either side makes that transition take effect in the interval in which the input changes. Each setting is captured when its timing interval starts. A change to a setting while an interval is already running has no effect on that interval. Typical uses are debouncing a status flag and requiring a protection condition to hold before it is acted on, with a separate hold-off before release.

Top module: `pdt_timer`

## Requirements
- R1: With pickup setting X > 0 and the output low, the output rises at the clock edge that ends the (X+1)-th consecutive tick cycle on which the input is high.
- R2: A tick cycle with the input low while the output is low and a pickup interval is running clears it. The output stays low, and a following high input needs X+1 new consecutive high ticks.
- R3: With pickup setting 0, the output rises at the edge that ends the first tick cycle on which the input is high.
- R4: With dropout setting 0, the output falls at the edge that ends the first tick cycle on which the input is low.
- R5: With dropout setting Y > 0 and the output high, the output falls at the edge that ends the (Y+1)-th consecutive tick cycle on which the input is low.
- R6: A tick cycle with the input high while the output is high and a dropout interval is running clears it. The output stays high, and a new release needs Y+1 new consecutive low ticks.
- R7: On cycles with the tick low, the input is ignored: the output and the running interval do not change.
- R8: Synchronous active-high reset drives the output low and clears any running interval.
- R9: Each 16-bit unsigned setting is sampled on the first tick of its interval. Later changes to it do not alter the length of that interval, and they take effect from the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Processing-interval enable, one cycle wide |
| din | input | 1 | Logic input to be qualified |
| pickup_len | input | 16 | Pickup delay in intervals, unsigned |
| dropout_len | input | 16 | Dropout delay in intervals, unsigned |
| qual_out | output | 1 | Registered qualified output |

## Verification
Every result of this block is due one clock edge after the tick cycle that completes it. The output flop changes at the edge that ends that tick cycle and at no other edge. Inputs are therefore driven on falling edges, and the output is read at the falling edge right after each tick. The expected value after the k-th consecutive qualifying tick (counting from zero) is k >= setting. In every step, the cycle after each tick is a non-tick cycle with the input inverted. The output is read again at the end of that cycle, so the hold behaviour is checked at the same time as the timing.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic {
    PDT_LOW  = 1'b0,
    PDT_HIGH = 1'b1
  } pdt_state_e;
endpackage

// File: rtl/pdt_run_counter.sv
module pdt_run_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (adv) begin
      count <= count + 1'b1;
    end
  end

  // The interval ends when count meets the limit, so it can never be asked to pass all-ones
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    adv |-> (count != CNT_MAX)); // R1
endmodule

// File: rtl/pdt_limit_hold.sv
module pdt_limit_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             use_pickup,
  input  logic [CNT_W-1:0] pickup_len,
  input  logic [CNT_W-1:0] dropout_len,
  output logic [CNT_W-1:0] active_lim
);
  logic [CNT_W-1:0] held_q;
  logic [CNT_W-1:0] fresh;

  assign fresh      = use_pickup ? pickup_len : dropout_len;
  assign active_lim = load ? fresh : held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (load) begin
      held_q <= fresh;
    end
  end
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             din,
  input  logic [CNT_W-1:0] pickup_len,
  input  logic [CNT_W-1:0] dropout_len,
  output logic             qual_out
);
  import pdt_pkg::*;

  pdt_state_e       state_q;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] active_lim;
  logic             out_high;
  logic             mismatch;
  logic             first_tick;
  logic             done;
  logic             cnt_adv;
  logic             cnt_clr;

  assign out_high   = (state_q == PDT_HIGH);
  assign mismatch   = tick && (din != out_high);
  assign first_tick = (run_cnt == '0);
  assign done       = mismatch && (run_cnt == active_lim);
  assign cnt_adv    = mismatch && !done;
  assign cnt_clr    = (tick && !mismatch) || done;

  pdt_limit_hold #(.CNT_W(CNT_W)) u_lim (
    .clk        (clk),
    .rst        (rst),
    .load       (mismatch && first_tick),
    .use_pickup (!out_high),
    .pickup_len (pickup_len),
    .dropout_len(dropout_len),
    .active_lim (active_lim)
  );

  pdt_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .adv  (cnt_adv),
    .clr  (cnt_clr),
    .count(run_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PDT_LOW;
    end else if (done) begin
      state_q <= out_high ? PDT_LOW : PDT_HIGH;
    end
  end

  assign qual_out = out_high;

  AST_RISE_NEEDS_HIGH_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(qual_out) |-> $past(tick && din)); // R1
  AST_FALL_NEEDS_LOW_TICK: assert property (@(posedge clk) disable iff (rst)
    ($fell(qual_out) && !$past(rst)) |-> $past(tick && !din)); // R5
  AST_MATCH_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
    (tick && (din == qual_out)) |=> (run_cnt == '0)); // R2
  AST_ZERO_PICKUP: assert property (@(posedge clk) disable iff (rst)
    (tick && din && !qual_out && (run_cnt == '0) && (pickup_len == '0)) |=> qual_out); // R3
  AST_ZERO_DROPOUT: assert property (@(posedge clk) disable iff (rst)
    (tick && !din && qual_out && (run_cnt == '0) && (dropout_len == '0)) |=> !qual_out); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(qual_out) && $stable(run_cnt))); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!qual_out && (run_cnt == '0))); // R8
endmodule

// File: tb/pdt_timer_bench.sv
module pdt_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        din = 1'b0;
  logic [15:0] pickup_len = '0;
  logic [15:0] dropout_len = '0;
  logic        qual_out;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  pdt_timer #(.CNT_W(16)) u_pdt_timer (
    .clk(clk), .rst(rst), .tick(tick), .din(din),
    .pickup_len(pickup_len), .dropout_len(dropout_len), .qual_out(qual_out)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: qual_out=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One tick with input v, then one idle cycle with the input inverted (R7)
  task automatic step(input logic v, input logic exp, input string tag);
    @(negedge clk); din = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0; din = ~v;
    chk(qual_out, exp, tag);
    @(negedge clk);
    chk(qual_out, exp, "R7 idle cycle ignores input");
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tick = 1'b0; din = 1'b0;
    @(negedge clk); rst = 1'b0;
    chk(qual_out, 1'b0, "R8 reset drives output low");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset();

    // Sweep of both settings: R1, R3, R4, R5
    for (int x = 0; x < 5; x++) begin
      for (int y = 0; y < 5; y++) begin
        do_reset();
        pickup_len = 16'(x); dropout_len = 16'(y);
        for (int k = 0; k < x + 2; k++)
          step(1'b1, (k >= x), (x == 0) ? "R3 zero pickup" : "R1 pickup timing");
        for (int k = 0; k < y + 2; k++)
          step(1'b0, !(k >= y), (y == 0) ? "R4 zero dropout" : "R5 dropout timing");
      end
    end

    // R2: an interrupted pickup restarts
    for (int x = 1; x < 5; x++) begin
      do_reset();
      pickup_len = 16'(x); dropout_len = 16'd0;
      for (int k = 0; k < x; k++) step(1'b1, 1'b0, "R2 pickup before interruption");
      step(1'b0, 1'b0, "R2 interruption keeps output low");
      for (int k = 0; k < x; k++) step(1'b1, 1'b0, "R2 restarted pickup not early");
      step(1'b1, 1'b1, "R2 restarted pickup completes");
    end

    // R6: reassertion during dropout restarts the dropout interval
    for (int y = 1; y < 5; y++) begin
      do_reset();
      pickup_len = 16'd0; dropout_len = 16'(y);
      step(1'b1, 1'b1, "R6 setup output high");
      for (int k = 0; k < y; k++) step(1'b0, 1'b1, "R6 dropout before reassert");
      step(1'b1, 1'b1, "R6 reassert keeps output high");
      for (int k = 0; k < y; k++) step(1'b0, 1'b1, "R6 restarted dropout not early");
      step(1'b0, 1'b0, "R6 restarted dropout completes");
    end

    // R7: long idle stretch with the input toggling
    do_reset();
    pickup_len = 16'd0; dropout_len = 16'd0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); din = k[0];
    end
    @(negedge clk);
    chk(qual_out, 1'b0, "R7 no tick means no change");

    // R9: settings captured at interval start
    do_reset();
    pickup_len = 16'd3; dropout_len = 16'd2;
    step(1'b1, 1'b0, "R9 pickup started");
    pickup_len = 16'd0;
    step(1'b1, 1'b0, "R9 pickup change ignored mid-interval");
    step(1'b1, 1'b0, "R9 pickup change ignored mid-interval");
    step(1'b1, 1'b1, "R9 captured pickup completes");
    step(1'b0, 1'b1, "R9 dropout started");
    dropout_len = 16'd5;
    step(1'b0, 1'b1, "R9 dropout change ignored mid-interval");
    step(1'b0, 1'b0, "R9 captured dropout completes");
    step(1'b1, 1'b1, "R9 new pickup setting applies next interval");

    // R8: reset clears a running interval and a high output
    do_reset();
    pickup_len = 16'd2; dropout_len = 16'd3;
    step(1'b1, 1'b0, "R8 partial pickup");
    step(1'b1, 1'b0, "R8 partial pickup");
    do_reset();
    step(1'b1, 1'b0, "R8 pickup restarted after reset");
    step(1'b1, 1'b0, "R8 pickup restarted after reset");
    step(1'b1, 1'b1, "R8 full pickup after reset");
    do_reset();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule